// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives asynchronous serial frames on a single line. It runs on a base clock and uses a tick pulse at sixteen times the bit rate to time each bit. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each good frame lands in a receive buffer register and raises a one-cycle completion pulse.

Three sticky error flags (parity, framing, overrun) sit in a status register. Software reads it with a one-cycle status-read strobe, which clears the flags. A buffer-read strobe marks the buffer as consumed. A power-enable input and a receive-enable input gate the receiver. When both are low, the flags clear and the status reads zero.

The frame state machine has five states. RX_IDLE waits for a start edge. RX_START re-checks the start bit at its middle. RX_DATA shifts in the data bits. RX_PARITY samples the parity bit. RX_STOP samples the stop bit and ends the frame. The transitions are:
- RX_IDLE to RX_START on a start edge.
- RX_START to RX_IDLE when the midpoint sample is high (false start).
- RX_START to RX_DATA when the midpoint sample is low.
- RX_DATA to RX_PARITY, or to RX_STOP when parity is off, after the last data bit.
- RX_PARITY to RX_STOP after the parity sample.
- RX_STOP to RX_IDLE after the stop sample.
- Any state to RX_IDLE whenever the receiver is inactive.

Top module: `serial_rx_status`

## Requirements
- R1: The receiver becomes active one clock after `power_en` and `rx_en` are both 1. Dropping either input returns it to idle and abandons any partial frame, and no frame completes while it is inactive.
- R2: A start is seen on a falling edge of the twice-synchronized line. A line that is already low when the receiver becomes active is also taken as a start bit.
- R3: The start bit is sampled again at its midpoint (8th tick). If the line is high there, the receiver returns to idle and no frame is produced.
- R4: Eight data bits are received least significant bit first, each sampled 16 ticks after the previous sample. A stored frame appears on `rx_data`, with `rx_done` high for exactly one clock.
- R5: `parity_mode` selects the parity bit: 00 none (no parity bit in the frame), 01 parity bit must be 0, 10 even parity over data plus parity bit, 11 odd. A mismatch sets status bit 2. With mode 00 bit 2 is never set.
- R6: Exactly one stop bit is checked, the first bit after the data or parity bit. If it is low, status bit 1 is set and the data is still stored.
- R7: If a frame completes while the buffer is still unread, status bit 0 is set and the new data is discarded. `rx_data` keeps the old value and `rx_done` stays low.
- R8: `status` is {5'b0, parity error, framing error, overrun}. A `stat_rd` pulse clears all flags on the next clock. A flag being set in the same cycle as a read survives the read.
- R9: While `power_en` and `rx_en` are both 0, `status` reads 8'h00, the flags are cleared and the buffer is marked empty.
- R10: `rx_err` pulses for one clock when a completing frame sets any error flag.
- R11: A `buf_rd` pulse marks the buffer consumed, so the next frame is stored without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| power_en | input | 1 | Power enable |
| rx_en | input | 1 | Receive enable |
| parity_mode | input | 2 | 00 none, 01 zero, 10 even, 11 odd |
| rxd | input | 1 | Serial input line, idle high |
| buf_rd | input | 1 | Buffer-read strobe |
| stat_rd | input | 1 | Status-read strobe, clears flags |
| rx_data | output | 8 | Receive buffer |
| status | output | 8 | Error status {5'b0, pe, fe, ov} |
| rx_done | output | 1 | One-cycle frame-stored pulse |
| rx_err | output | 1 | One-cycle error pulse |

## Verification
A wrong bit counter or sample point shows up as a wrong `rx_data` value, or as a false parity or framing flag. It appears within the frame being received, about one bit time after its stop-bit midpoint. A state machine stuck out of idle shows as a missing `rx_done` on the next frame. Wrong buffer-full tracking shows as a spurious or missing overrun on the second frame after a read. Bad enable gating shows as a completed frame while disabled, or as a nonzero status in the disabled state.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rxd,
    output logic rxd_s,
    output logic start_det
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            // Forced high while inactive: a line low at enable reads as an edge
            prev_q <= active ? sync_q[SYNC_STAGES-1] : 1'b1;
        end
    end

    assign rxd_s     = sync_q[SYNC_STAGES-1];
    assign start_det = active && prev_q && !rxd_s;

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16   // oversampling ratio, power of two
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              start_det,
    input  logic              par_en,
    output logic              frame_end,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_par,
    output logic              frm_stop
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q, stop_q, end_q;
    logic              sample_mid, sample_bit;

    assign sample_mid = tick && (cnt_q == MID_CNT);
    assign sample_bit = tick && (cnt_q == LAST_CNT);

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:   if (start_det)  state_d = RX_START;
                RX_START:  if (sample_mid) state_d = rxd_s ? RX_IDLE : RX_DATA;
                RX_DATA:   if (sample_bit && bit_q == LAST_BIT)
                               state_d = par_en ? RX_PARITY : RX_STOP;
                RX_PARITY: if (sample_bit) state_d = RX_STOP;
                RX_STOP:   if (sample_bit) state_d = RX_IDLE;
                default:   state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            stop_q  <= 1'b1;
            end_q   <= 1'b0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (tick)          cnt_q <= cnt_q + 1'b1;
            if (state_q == RX_START) bit_q <= '0;
            if (state_q == RX_DATA && sample_bit) begin
                shreg_q <= {rxd_s, shreg_q[DATA_W-1:1]};
                bit_q   <= bit_q + 1'b1;
            end
            if (state_q == RX_PARITY && sample_bit) par_q <= rxd_s;
            end_q <= active && state_q == RX_STOP && sample_bit;
            if (active && state_q == RX_STOP && sample_bit) stop_q <= rxd_s;
        end
    end

    assign frame_end = end_q;
    assign frm_data  = shreg_q;
    assign frm_par   = par_q;
    assign frm_stop  = stop_q;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> state_q == RX_IDLE);                                  // R1
    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state_q == RX_START && sample_mid && rxd_s) |=> state_q == RX_IDLE); // R3
    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |=> !end_q);                                                // R4

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              frame_end,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_par,
    input  logic              frm_stop,
    input  par_mode_t         par_mode,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic [2:0]        err_flags,
    output logic              rx_done,
    output logic              rx_err
);
    logic              full_q;
    logic              exp_par, new_pe, new_fe, new_ov, store;
    logic [2:0]        new_flags;

    always_comb begin
        unique case (par_mode)
            PAR_EVEN: exp_par = ^frm_data;
            PAR_ODD:  exp_par = ~^frm_data;
            default:  exp_par = 1'b0;
        endcase
    end

    assign new_pe    = frame_end && par_mode != PAR_NONE && frm_par != exp_par;
    assign new_fe    = frame_end && !frm_stop;
    assign new_ov    = frame_end && full_q;
    assign store     = frame_end && !full_q;
    assign new_flags = {new_pe, new_fe, new_ov};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            err_flags <= '0;
            full_q    <= 1'b0;
            rx_done   <= 1'b0;
            rx_err    <= 1'b0;
        end else if (clr) begin
            err_flags <= '0;
            full_q    <= 1'b0;
            rx_done   <= 1'b0;
            rx_err    <= 1'b0;
        end else begin
            // a flag raised this cycle outlives a simultaneous read
            err_flags <= (stat_rd ? 3'b000 : err_flags) | new_flags;
            if (store) rx_data <= frm_data;
            full_q  <= store || (full_q && !buf_rd);
            rx_done <= store;
            rx_err  <= |new_flags;
        end
    end

    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && full_q && !clr) |=> (rx_data == $past(rx_data) && !rx_done && err_flags[0])); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !frame_end) |=> err_flags == 3'b000);                 // R8
    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_flags == 3'b000 && !rx_done));                       // R9
    AST_NOPAR_PE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && par_mode == PAR_NONE && (stat_rd || !err_flags[2])) |=> !err_flags[2]); // R5
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> $past(frame_end));                                     // R10

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              power_en,
    input  logic              rx_en,
    input  logic [1:0]        parity_mode,
    input  logic              rxd,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status,
    output logic              rx_done,
    output logic              rx_err
);
    logic       active_q, clr;
    logic       rxd_s, start_det;
    logic       frame_end, frm_par, frm_stop;
    logic [DATA_W-1:0] frm_data;
    logic [2:0] flags;
    par_mode_t  pmode;

    assign pmode = par_mode_t'(parity_mode);
    assign clr   = !power_en && !rx_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= power_en && rx_en;
    end

    rx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .active(active_q), .rxd(rxd),
        .rxd_s(rxd_s), .start_det(start_det)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active_q), .tick(tick16),
        .rxd_s(rxd_s), .start_det(start_det), .par_en(pmode != PAR_NONE),
        .frame_end(frame_end), .frm_data(frm_data), .frm_par(frm_par),
        .frm_stop(frm_stop)
    );

    rx_status_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(clr), .frame_end(frame_end),
        .frm_data(frm_data), .frm_par(frm_par), .frm_stop(frm_stop),
        .par_mode(pmode), .buf_rd(buf_rd), .stat_rd(stat_rd),
        .rx_data(rx_data), .err_flags(flags), .rx_done(rx_done), .rx_err(rx_err)
    );

    assign status = clr ? 8'h00 : {5'b00000, flags};

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:3] == 5'b00000);                                         // R8
    AST_NO_FRAME_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |=> !rx_done);                                          // R1

endmodule

// File: tb/sim_serial_rx_status.sv
`timescale 1ns/1ps
module sim_serial_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       power_en = 1'b0, rx_en = 1'b0;
    logic [1:0] parity_mode = 2'b00;
    logic       rxd = 1'b1, buf_rd = 1'b0, stat_rd = 1'b0;
    logic [7:0] rx_data, status;
    logic       rx_done, rx_err;

    int checks = 0, errors = 0;
    int done_cnt = 0, err_cnt = 0;
    logic prev_done = 1'b0;
    bit finished = 0;
    logic [1:0] div = '0;

    localparam int BIT_CLKS = 64;   // 16 ticks x 4 clocks

    always #2 clk = ~clk;           // 250 MHz

    always @(posedge clk) begin
        div    <= div + 1'b1;
        tick16 <= (div == 2'd3);
    end

    serial_rx_status u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .power_en(power_en),
        .rx_en(rx_en), .parity_mode(parity_mode), .rxd(rxd), .buf_rd(buf_rd),
        .stat_rd(stat_rd), .rx_data(rx_data), .status(status),
        .rx_done(rx_done), .rx_err(rx_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (rx_done) done_cnt++;
        if (rx_err)  err_cnt++;
        if (rx_done && prev_done) begin
            errors++;
            $display("FAIL R4: rx_done wider than one cycle, actual 2 expected 1");
        end
        prev_done = rx_done;
    end

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] m);
        case (m)
            2'b10:   return ^d;
            2'b11:   return ~^d;
            default: return 1'b0;
        endcase
    endfunction

    task automatic line(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] m,
                        input logic bad_par, input logic stop_v);
        line(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) line(d[i], BIT_CLKS);
        if (m != 2'b00) line(par_bit(d, m) ^ bad_par, BIT_CLKS);
        line(stop_v, BIT_CLKS);
        line(1'b1, BIT_CLKS);
    endtask

    task automatic pulse_reads();
        stat_rd = 1'b1; buf_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; buf_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dc, ec;
        logic [7:0] d, a;
        logic [1:0] m;
        logic bp, bs;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset status", status, 8'h00);
        check("R4 reset rx_done", rx_done, 0);
        check("R4 reset rx_data", rx_data, 8'h00);

        power_en = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // random frames, R4 R5 R6 R8 R10
        for (int k = 0; k < 24; k++) begin
            d  = 8'($urandom);
            m  = 2'($urandom % 4);
            bp = (m != 2'b00) && ($urandom % 4 == 0);
            bs = ($urandom % 5 == 0);
            parity_mode = m;
            pulse_reads();
            dc = done_cnt; ec = err_cnt;
            send(d, m, bp, !bs);
            check("R4 data", rx_data, d);
            check("R4 one done", done_cnt - dc, 1);
            check("R5 R6 R8 status", status, {5'b0, bp, bs, 1'b0});
            check("R10 err pulse", err_cnt - ec, (bp || bs) ? 1 : 0);
        end

        // R5: mode none never flags parity
        parity_mode = 2'b00;
        pulse_reads();
        send(8'h5A, 2'b00, 1'b0, 1'b1);
        check("R5 none no pe", status[2], 0);

        // R7 overrun, R8 read clear, R11 buffer consumed
        pulse_reads();
        send(8'hA1, 2'b00, 1'b0, 1'b1);
        dc = done_cnt; ec = err_cnt;
        send(8'h3C, 2'b00, 1'b0, 1'b1);
        check("R7 old data kept", rx_data, 8'hA1);
        check("R7 overrun flag", status, 8'h01);
        check("R7 no done on overrun", done_cnt - dc, 0);
        check("R10 err on overrun", err_cnt - ec, 1);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
        check("R8 read clears", status, 8'h00);
        buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
        dc = done_cnt;
        send(8'hC7, 2'b00, 1'b0, 1'b1);
        check("R11 stored after buf_rd", rx_data, 8'hC7);
        check("R11 no overrun", status, 8'h00);
        check("R11 done", done_cnt - dc, 1);

        // R3 false start
        pulse_reads();
        dc = done_cnt;
        line(1'b0, 12);
        line(1'b1, 14 * BIT_CLKS);
        check("R3 false start ignored", done_cnt - dc, 0);
        check("R3 status clean", status, 8'h00);

        // R9 disabled clears flags
        send(8'h11, 2'b00, 1'b0, 1'b0);
        check("R6 framing flag", status, 8'h02);
        check("R6 data stored", rx_data, 8'h11);
        power_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        check("R9 status zero when off", status, 8'h00);
        dc = done_cnt;
        send(8'h22, 2'b00, 1'b0, 1'b1);
        check("R1 no frame while off", done_cnt - dc, 0);
        check("R1 buffer untouched", rx_data, 8'h11);
        power_en = 1'b1;
        @(negedge clk);
        check("R9 flags cleared", status, 8'h00);
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // R1 abort mid-frame
        dc = done_cnt;
        line(1'b0, BIT_CLKS);
        line(1'b1, BIT_CLKS);
        line(1'b0, BIT_CLKS);
        rx_en = 1'b0;
        line(1'b1, 4);
        rx_en = 1'b1;
        line(1'b1, 12 * BIT_CLKS);
        check("R1 abort drops frame", done_cnt - dc, 0);

        // R2 low line at enable starts a frame
        rx_en = 1'b0;
        line(1'b0, 10);
        dc = done_cnt;
        a  = 8'h96;
        rx_en = 1'b1;
        line(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) line(a[i], BIT_CLKS);
        line(1'b1, 2 * BIT_CLKS);
        check("R2 start on low enable", done_cnt - dc, 1);
        check("R2 data", rx_data, 8'h96);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule